// File: doc/BRIEF.md
# Cursor Register Shadow Bank with Update Arming

This block holds the programming state of one hardware cursor. Each of its four registers (control, position, base address and partial-height clip) exists twice: a pending copy that software writes, and an active copy that the display pipeline uses. Software writes never reach the active copies directly. A small arming rule decides when the pending set is ready. An armed update is copied to the active set on the next vertical-blank pulse.

A write to the base register arms the update. A write to the control register also arms it when the cursor is currently disabled and the new mode is non-zero, so turning the cursor on needs no base write. Every other write cancels an armed update: a position write, a clip write, or a control write while the cursor is enabled. Because of this rule, software must write the base register last. The read port returns the active copies, so software and the bench see what the pipeline sees.

Top module: `cursor_shadow_regs`

## Requirements
- R1: After reset, all four active registers read zero, the armed flag is 0 and the enabled status is 0.
- R2: A register write changes only the pending copy. The active copy read back is unchanged until a transfer happens.
- R3: A write to address 2 (base) sets the armed flag. On the next vertical-blank pulse, all four pending registers are copied to the active set.
- R4: A write to address 1 (position) on its own does not arm. A vertical-blank pulse that follows it leaves the active set unchanged.
- R5: While armed, a write to any register other than a base write clears the armed flag. A later base write re-arms the update.
- R6: A write to address 0 (control) whose mode field, bits [2:0], is non-zero arms the update when the active cursor is disabled.
- R7: A control write while the active cursor is enabled does not arm. It cancels any armed update.
- R8: The enabled status is 1 exactly when bits [2:0] of the active control register are non-zero.
- R9: When a write and a vertical-blank pulse occur in the same cycle, the write goes to pending and no transfer takes place. The armed flag then follows the write rule.
- R10: A transfer clears the armed flag. A vertical-blank pulse with nothing armed has no effect.
- R11: The read address selects the active register: 0 control, 1 position, 2 base, 3 partial-height clip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| vblank | input | 1 | Vertical-blank start pulse |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Active register value |
| cur_enabled | output | 1 | Active control mode is non-zero |
| armed | output | 1 | Pending update armed |

## Verification
The hardest case to reach is a write and a vertical-blank pulse in the same cycle while an update is already armed. Whether the transfer is suppressed, and what state the armed flag is left in, both depend on the kind of write. The directed stimulus first arms the update with a base write. It then applies a clip write together with the pulse, and later a base write together with the pulse. Between those steps, it reads back the active set and the armed flag. The enable-on-control rule is covered in both directions: once from the disabled state and once from the enabled state.

// File: rtl/cursor_shadow_regs.sv
module cursor_shadow_regs #(
  parameter int DATA_W = 32,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vblank,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              cur_enabled,
  output logic              armed
);
  localparam int NREG = 4;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_POS  = 2'd1;
  localparam logic [1:0] A_BASE = 2'd2;
  localparam logic [1:0] A_CLIP = 2'd3;

  logic [DATA_W-1:0] pend [NREG];
  logic [DATA_W-1:0] act  [NREG];
  logic armed_q, arm_nxt, xfer, wr_mode_on;

  assign wr_mode_on  = |wr_data[MODE_W-1:0];
  assign xfer        = vblank && armed_q && !wr_en;
  assign cur_enabled = |act[A_CTRL][MODE_W-1:0];
  assign rd_data     = act[rd_addr];
  assign armed       = armed_q;

  always_comb begin
    arm_nxt = armed_q;
    if (wr_en) begin
      if (wr_addr == A_BASE)
        arm_nxt = 1'b1;
      else if (wr_addr == A_CTRL && !cur_enabled && wr_mode_on)
        arm_nxt = 1'b1;
      else
        arm_nxt = 1'b0;
    end else if (xfer) begin
      arm_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        pend[i] <= '0;
        act[i]  <= '0;
      end
      armed_q <= 1'b0;
    end else begin
      if (wr_en) pend[wr_addr] <= wr_data;
      if (xfer)
        for (int i = 0; i < NREG; i++) act[i] <= pend[i];
      armed_q <= arm_nxt;
    end
  end

  p_base_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_BASE |=> armed);

  p_pos_cancels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == A_POS || wr_addr == A_CLIP) |=> !armed);

  p_enable_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CTRL && !cur_enabled && wr_data[MODE_W-1:0] != '0 |=> armed);

  p_ctrl_enabled_no_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_CTRL && cur_enabled |=> !armed);

  p_write_beats_vblank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && vblank |=> $stable({act[0], act[1], act[2], act[3]}));

  p_xfer_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vblank && armed && !wr_en |=> !armed);

  p_idle_vblank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable({act[0], act[1], act[2], act[3]}));
endmodule

// File: tb/cursor_shadow_regs_tb.sv
module cursor_shadow_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        vblank = 0;
  logic [1:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        cur_enabled, armed;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cursor_shadow_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank(vblank), .rd_addr(rd_addr), .rd_data(rd_data),
    .cur_enabled(cur_enabled), .armed(armed)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d, input logic vb);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; vblank = vb;
    @(negedge clk);
    wr_en = 0; vblank = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic vb();
    cyc(1'b0, 2'd0, 32'd0, 1'b1);
  endtask

  task automatic chk_act(input string req, input logic [31:0] c, input logic [31:0] p,
                         input logic [31:0] b, input logic [31:0] h);
    logic [31:0] v;
    rd(2'd0, v); chk({req, " R11 ctrl"}, v, c);
    rd(2'd1, v); chk({req, " R11 pos"},  v, p);
    rd(2'd2, v); chk({req, " R11 base"}, v, b);
    rd(2'd3, v); chk({req, " R11 clip"}, v, h);
  endtask

  task automatic t_reset();
    chk_act("R1", 0, 0, 0, 0);
    chk("R1 armed", armed, 0);
    chk("R1 enabled", cur_enabled, 0);
  endtask

  task automatic t_first_load();
    wr(2'd0, 32'h0000_0100);
    chk("R6 mode0 no arm", armed, 0);
    wr(2'd1, 32'h0020_0010);
    wr(2'd3, 32'h8000_003F);
    wr(2'd2, 32'h0000_A000);
    chk("R3 armed", armed, 1);
    chk_act("R2 pending only", 0, 0, 0, 0);
    vb();
    chk_act("R3 transfer", 32'h100, 32'h0020_0010, 32'hA000, 32'h8000_003F);
    chk("R10 cleared", armed, 0);
    chk("R8 mode0 disabled", cur_enabled, 0);
  endtask

  task automatic t_pos_alone();
    wr(2'd1, 32'h55);
    chk("R4 no arm", armed, 0);
    vb();
    chk_act("R4 R10 idle vblank", 32'h100, 32'h0020_0010, 32'hA000, 32'h8000_003F);
  endtask

  task automatic t_enable_arms();
    wr(2'd0, 32'h27);
    chk("R6 armed", armed, 1);
    vb();
    chk_act("R6 transfer", 32'h27, 32'h55, 32'hA000, 32'h8000_003F);
    chk("R8 enabled", cur_enabled, 1);
  endtask

  task automatic t_ctrl_enabled();
    wr(2'd0, 32'h26);
    chk("R7 no arm", armed, 0);
    vb();
    chk_act("R7 no transfer", 32'h27, 32'h55, 32'hA000, 32'h8000_003F);
  endtask

  task automatic t_cancel();
    wr(2'd2, 32'hB000);
    chk("R5 armed", armed, 1);
    wr(2'd1, 32'h77);
    chk("R5 cancelled", armed, 0);
    vb();
    chk_act("R5 no transfer", 32'h27, 32'h55, 32'hA000, 32'h8000_003F);
    wr(2'd2, 32'hC000);
    chk("R5 rearmed", armed, 1);
    vb();
    chk_act("R5 transfer", 32'h26, 32'h77, 32'hC000, 32'h8000_003F);
  endtask

  task automatic t_same_cycle();
    wr(2'd2, 32'hD000);
    cyc(1'b1, 2'd3, 32'h12, 1'b1);
    chk("R9 clip cancels", armed, 0);
    chk_act("R9 no transfer", 32'h26, 32'h77, 32'hC000, 32'h8000_003F);
    cyc(1'b1, 2'd2, 32'hE000, 1'b1);
    chk("R9 base arms", armed, 1);
    chk_act("R9 still no transfer", 32'h26, 32'h77, 32'hC000, 32'h8000_003F);
    vb();
    chk_act("R9 later transfer", 32'h26, 32'h77, 32'hE000, 32'h12);
  endtask

  task automatic t_disable();
    wr(2'd0, 32'h0);
    chk("R7 disable no arm", armed, 0);
    wr(2'd2, 32'hE000);
    vb();
    chk("R8 disabled", cur_enabled, 0);
    chk_act("R8 ctrl zero", 32'h0, 32'h77, 32'hE000, 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_load();
    t_pos_alone();
    t_enable_arms();
    t_ctrl_enabled();
    t_cancel();
    t_same_cycle();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule